// File: doc/BRIEF.md
# Genetic Operator Engine for LUT Chromosomes

This block runs one generation of a genetic search over a small population held in on-chip registers. Each individual is a chromosome made of several 16-bit genes. Each gene is the truth table of a 4-input lookup table. While the engine is idle, the host loads chromosomes through a word-wide read/write bus and writes one fitness value per individual.

A start pulse runs one generation. First the best individual, or the best two, are copied unchanged into the next generation. Every other slot then receives a child. The engine picks two parents by tournament selection, may combine them with a single cut at a gene boundary, and may overwrite one gene with random bits. All of these decisions draw on a 32-bit pseudo-random source that is seeded at start.

At the end of the generation the new population replaces the old one in a single cycle, and `done` pulses. Population size, genes per chromosome, tournament size, elite count and the two event probabilities are all run-time inputs, sampled at start.

Top module: `ga_lut_engine`

## Requirements
- R1: After reset, `busy` and `done` are low and every gene of every individual reads back as zero.
- R2: While idle, `chr_we` writes `chr_wdata` to gene `chr_gene` of individual `chr_idx`, and `chr_rdata` shows the addressed gene combinationally. While `busy` is high, chromosome writes and fitness writes are ignored.
- R3: Slot 0 of the new generation is an unchanged copy of the individual with the highest fitness, with ties going to the lower index. When `elite_two` is 1, slot 1 receives the best of the remaining individuals under the same rule.
- R4: Random draws come from a 32-bit Galois LFSR that shifts right and XORs in the mask 0x80200003 when the bit shifted out is 1. The LFSR is loaded from `seed` at start, and a zero seed is replaced by 0xACE12468. Each draw steps the state once and uses the new state.
- R5: Each child is built from draws in a fixed order: `tour_size` draws for parent A, `tour_size` draws for parent B, one crossover draw, then one mutation draw. Children fill slots in rising order after the elites. A tournament candidate is (draw[15:0] * pop_size) >> 16. Across the tournament, the highest fitness wins, and on equal fitness the lower index wins.
- R6: A crossover happens when the crossover draw's bits [7:0] are below `xover_thr`. The cut is then 1 + ((draw[31:16] * (gene_cnt-1)) >> 16). Genes below the cut come from parent A and all other genes from parent B. Without a crossover, the child is a copy of parent A.
- R7: A mutation happens when the mutation draw's bits [7:0] are below `mut_thr`. Gene number (draw[15:8] * gene_cnt) >> 8 of the child is then replaced by draw[31:16].
- R8: `busy` rises in the cycle after an accepted start. When the generation completes, the new population becomes visible, `busy` falls and `done` is high for exactly one cycle. A start pulse during `busy` is ignored.
- R9: `pop_size` (5..20), `gene_cnt` (2..13), `tour_size` (1..8), `elite_two`, the thresholds and `seed` are sampled at start. Changes to them while busy have no effect. Slots at or beyond `pop_size` keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Run one generation (accepted when idle) |
| seed | input | 32 | LFSR seed, sampled at start |
| pop_size | input | 5 | Individuals in use |
| gene_cnt | input | 4 | Genes per chromosome in use |
| tour_size | input | 4 | Tournament size |
| elite_two | input | 1 | 0: one elite, 1: two elites |
| xover_thr | input | 8 | Crossover threshold |
| mut_thr | input | 8 | Mutation threshold |
| fit_we | input | 1 | Fitness write strobe |
| fit_idx | input | 5 | Fitness write index |
| fit_val | input | 16 | Fitness value |
| chr_we | input | 1 | Gene write strobe |
| chr_idx | input | 5 | Individual address |
| chr_gene | input | 4 | Gene address |
| chr_wdata | input | 16 | Gene write data |
| chr_rdata | output | 16 | Addressed gene |
| busy | output | 1 | Generation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Crossover and mutation can act on the same child in the same draw sequence, and the mutated gene may fall on either side of the cut. The bench sets both thresholds to 255 so that the two nearly always fire together, then sets both to 0 so that children are plain copies of tournament winners. Each run is judged against a bench model that replays the LFSR, the tournaments, the cut and the mutation and compares every gene of every slot. A second collision comes from host writes and a stray start arriving while a generation is running. The bench drives them in the busy cycle and expects a result identical to a run without them.

// File: rtl/ga_pkg.sv
// Shared constants and the engine state type.
// Assumes genes are 16-bit truth tables of 4-input LUTs.
package ga_pkg;
    localparam int GENE_W = 16;
    localparam logic [31:0] LFSR_MASK = 32'h8020_0003;
    localparam logic [31:0] SEED_ALT  = 32'hACE1_2468;

    typedef enum logic [2:0] {
        S_IDLE, S_ELITE, S_TA, S_TB, S_XO, S_MUT, S_COMMIT
    } ga_state_t;
endpackage

// File: rtl/ga_lfsr.sv
// 32-bit Galois LFSR. Loads a seed (zero swapped for a constant) and
// steps once per advance; 'draw' is the state after the next step.
module ga_lfsr
    import ga_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] seed,
    input  logic        adv,
    output logic [31:0] draw
);
    logic [31:0] st_q;

    // next-state value for one right shift
    always_comb draw = st_q[0] ? ((st_q >> 1) ^ LFSR_MASK) : (st_q >> 1);

    // seed load or step
    always_ff @(posedge clk) begin
        if (!rst_n)       st_q <= SEED_ALT;
        else if (load)    st_q <= (seed == 32'h0) ? SEED_ALT : seed;
        else if (adv)     st_q <= draw;
    end

    // R4
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != 32'h0);
endmodule

// File: rtl/ga_splice.sv
// Combinational child builder: single cut at a gene boundary, then an
// optional one-gene overwrite. Assumes cut in 1..NG (NG = no cut).
module ga_splice #(
    parameter int NG  = 13,
    parameter int GW  = 16,
    parameter int GCW = 4
) (
    input  logic [NG*GW-1:0] par_a,
    input  logic [NG*GW-1:0] par_b,
    input  logic [GCW-1:0]   cut,
    input  logic             mut_en,
    input  logic [GCW-1:0]   mut_idx,
    input  logic [GW-1:0]    mut_val,
    output logic [NG*GW-1:0] child
);
    for (genvar g = 0; g < NG; g++) begin : g_gene
        // pick parent by cut position, then apply mutation
        always_comb begin
            child[g*GW +: GW] = (GCW'(g) < cut) ? par_a[g*GW +: GW] : par_b[g*GW +: GW];
            if (mut_en && mut_idx == GCW'(g)) child[g*GW +: GW] = mut_val;
        end
    end
endmodule

// File: rtl/ga_lut_engine.sv
// One-generation genetic engine: elitism, tournament selection,
// single-point crossover and one-gene mutation over LUT chromosomes.
// Assumes run-time settings are within their stated ranges.
module ga_lut_engine
    import ga_pkg::*;
#(
    parameter int POP_MAX = 20,
    parameter int NG      = 13,
    parameter int FW      = 16,
    parameter int TOUR_MAX = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [31:0]          seed,
    input  logic [$clog2(POP_MAX+1)-1:0] pop_size,
    input  logic [$clog2(NG+1)-1:0]      gene_cnt,
    input  logic [$clog2(TOUR_MAX+1)-1:0] tour_size,
    input  logic                 elite_two,
    input  logic [7:0]           xover_thr,
    input  logic [7:0]           mut_thr,
    input  logic                 fit_we,
    input  logic [$clog2(POP_MAX+1)-1:0] fit_idx,
    input  logic [FW-1:0]        fit_val,
    input  logic                 chr_we,
    input  logic [$clog2(POP_MAX+1)-1:0] chr_idx,
    input  logic [$clog2(NG+1)-1:0]      chr_gene,
    input  logic [GENE_W-1:0]    chr_wdata,
    output logic [GENE_W-1:0]    chr_rdata,
    output logic                 busy,
    output logic                 done
);
    localparam int IW  = $clog2(POP_MAX+1);
    localparam int GCW = $clog2(NG+1);
    localparam int TW  = $clog2(TOUR_MAX+1);
    localparam int CW  = NG*GENE_W;
    localparam int PW  = 16+IW;
    localparam int XW  = 16+GCW;
    localparam int MW  = 8+GCW;
    localparam logic [IW-1:0]  POP_LIM = IW'(POP_MAX);
    localparam logic [GCW-1:0] NG_LIM  = GCW'(NG);

    logic [CW-1:0] cur [POP_MAX];
    logic [CW-1:0] nxt [POP_MAX];
    logic [FW-1:0] fit [POP_MAX];

    ga_state_t      st;
    logic [IW-1:0]  pop_q, i_q, bidx, el0, child_q, win_q, pa_q, pb_q, cand, best_n, win_n;
    logic [GCW-1:0] gcnt_q, cut_q, cut_n, midx;
    logic [TW-1:0]  tour_q, t_q;
    logic [7:0]     xthr_q, mthr_q;
    logic           two_q, e_q, bvalid, adv, load;
    logic [31:0]    nv;
    logic [PW-1:0]  cprod;
    logic [XW-1:0]  xprod;
    logic [MW-1:0]  mprod;
    logic [CW-1:0]  child;

    ga_lfsr u_lfsr (.clk(clk), .rst_n(rst_n), .load(load), .seed(seed), .adv(adv), .draw(nv));

    ga_splice #(.NG(NG), .GW(GENE_W), .GCW(GCW)) u_splice (
        .par_a(cur[pa_q]), .par_b(cur[pb_q]), .cut(cut_q),
        .mut_en(nv[7:0] < mthr_q), .mut_idx(midx), .mut_val(nv[31:16]), .child(child));

    // host read port
    always_comb chr_rdata = (chr_idx < POP_LIM && chr_gene < NG_LIM)
                            ? cur[chr_idx][int'(chr_gene)*GENE_W +: GENE_W] : '0;

    // draw-derived values: candidate, cut, mutated gene index
    always_comb begin
        load  = (st == S_IDLE) && start;
        adv   = (st == S_TA) || (st == S_TB) || (st == S_XO) || (st == S_MUT);
        cprod = PW'(nv[15:0]) * PW'(pop_q);
        cand  = cprod[PW-1:16];
        xprod = XW'(nv[31:16]) * XW'(gcnt_q - 1'b1);
        cut_n = (nv[7:0] < xthr_q) ? xprod[XW-1:16] + 1'b1 : NG_LIM;
        mprod = MW'(nv[15:8]) * MW'(gcnt_q);
        midx  = mprod[MW-1:8];
    end

    // elite scan and tournament comparisons
    always_comb begin
        best_n = bidx;
        if (!(e_q && i_q == el0) && (!bvalid || fit[i_q] > fit[bidx])) best_n = i_q;
        win_n = win_q;
        if (t_q == '0 || fit[cand] > fit[win_q] || (fit[cand] == fit[win_q] && cand < win_q))
            win_n = cand;
    end

    // control, population storage and host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; busy <= 1'b0; done <= 1'b0;
            pop_q <= '0; i_q <= '0; bidx <= '0; el0 <= '0; child_q <= '0;
            win_q <= '0; pa_q <= '0; pb_q <= '0; gcnt_q <= '0; cut_q <= '0;
            tour_q <= '0; t_q <= '0; xthr_q <= '0; mthr_q <= '0;
            two_q <= 1'b0; e_q <= 1'b0; bvalid <= 1'b0;
            for (int p = 0; p < POP_MAX; p++) begin
                cur[p] <= '0; nxt[p] <= '0; fit[p] <= '0;
            end
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (chr_we && chr_idx < POP_LIM && chr_gene < NG_LIM)
                        cur[chr_idx][int'(chr_gene)*GENE_W +: GENE_W] <= chr_wdata;
                    if (fit_we && fit_idx < POP_LIM) fit[fit_idx] <= fit_val;
                    if (start) begin
                        pop_q <= pop_size; gcnt_q <= gene_cnt; tour_q <= tour_size;
                        two_q <= elite_two; xthr_q <= xover_thr; mthr_q <= mut_thr;
                        for (int p = 0; p < POP_MAX; p++) nxt[p] <= cur[p];
                        i_q <= '0; e_q <= 1'b0; bvalid <= 1'b0; busy <= 1'b1;
                        st <= S_ELITE;
                    end
                end
                S_ELITE: begin
                    if (i_q == pop_q - 1'b1) begin
                        nxt[e_q ? 1 : 0] <= cur[best_n];
                        if (!e_q && two_q) begin
                            e_q <= 1'b1; el0 <= best_n; i_q <= '0; bvalid <= 1'b0;
                        end else begin
                            child_q <= two_q ? IW'(2) : IW'(1);
                            t_q <= '0; st <= S_TA;
                        end
                    end else begin
                        i_q <= i_q + 1'b1; bidx <= best_n;
                        bvalid <= bvalid | !(e_q && i_q == el0);
                    end
                end
                S_TA, S_TB: begin
                    if (t_q == tour_q - 1'b1) begin
                        t_q <= '0; win_q <= '0;
                        if (st == S_TA) begin pa_q <= win_n; st <= S_TB; end
                        else            begin pb_q <= win_n; st <= S_XO; end
                    end else begin
                        t_q <= t_q + 1'b1; win_q <= win_n;
                    end
                end
                S_XO: begin
                    cut_q <= cut_n; st <= S_MUT;
                end
                S_MUT: begin
                    nxt[child_q] <= child;
                    if (child_q == pop_q - 1'b1) st <= S_COMMIT;
                    else begin child_q <= child_q + 1'b1; st <= S_TA; end
                end
                S_COMMIT: begin
                    for (int p = 0; p < POP_MAX; p++) cur[p] <= nxt[p];
                    busy <= 1'b0; done <= 1'b1; st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
    // R5
    cand_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_TA || st == S_TB) |-> cand < pop_q);
    // R6
    cut_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_MUT) |-> (cut_q == NG_LIM || (cut_q >= 1 && cut_q < gcnt_q)));
    // R7
    mut_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_MUT) |-> midx < gcnt_q);
    // R3
    elite_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_TA && $past(st) == S_ELITE) |-> !(two_q && el0 == $past(best_n)));
endmodule

// File: tb/sim_ga_lut_engine.sv
module sim_ga_lut_engine;
    localparam logic [31:0] MASK = 32'h8020_0003;
    localparam logic [31:0] ALT  = 32'hACE1_2468;
    localparam int PM = 20, NGM = 13;

    logic clk = 0, rst_n = 0, start = 0, elite_two = 0, fit_we = 0, chr_we = 0;
    logic [31:0] seed = 0;
    logic [4:0] pop_size = 10, fit_idx = 0, chr_idx = 0;
    logic [3:0] gene_cnt = 8, tour_size = 6, chr_gene = 0;
    logic [7:0] xover_thr = 153, mut_thr = 128;
    logic [15:0] fit_val = 0, chr_wdata = 0;
    logic [15:0] chr_rdata;
    logic busy, done;

    int ncmp = 0, nbad = 0;
    logic [15:0] mcur [PM][NGM];
    logic [15:0] mnxt [PM][NGM];
    logic [15:0] mfit [PM];
    logic [31:0] ms;

    always #10 clk = ~clk;

    ga_lut_engine u0 (.*);

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        ncmp++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic mstep();
        ms = ms[0] ? ((ms >> 1) ^ MASK) : (ms >> 1);
    endtask

    function automatic int mbest(int pop, int excl);
        int b = -1;
        for (int i = 0; i < pop; i++)
            if (i != excl && (b < 0 || mfit[i] > mfit[b])) b = i;
        return b;
    endfunction

    task automatic mtour(int pop, int tr, output int w);
        w = 0;
        for (int t = 0; t < tr; t++) begin
            int c;
            mstep();
            c = (int'(ms[15:0]) * pop) >> 16;
            if (t == 0 || mfit[c] > mfit[w] || (mfit[c] == mfit[w] && c < w)) w = c;
        end
    endtask

    // bench model of one generation from the requirements (R3..R7)
    task automatic model_gen(logic [31:0] sd, int pop, int ng, int tr, bit two, int xt, int mt);
        int b0, b1, pa, pb, cut, nel;
        ms = (sd == 0) ? ALT : sd;
        for (int p = 0; p < PM; p++) for (int g = 0; g < NGM; g++) mnxt[p][g] = mcur[p][g];
        b0 = mbest(pop, -1);
        for (int g = 0; g < NGM; g++) mnxt[0][g] = mcur[b0][g];
        nel = 1;
        if (two) begin
            b1 = mbest(pop, b0);
            for (int g = 0; g < NGM; g++) mnxt[1][g] = mcur[b1][g];
            nel = 2;
        end
        for (int c = nel; c < pop; c++) begin
            mtour(pop, tr, pa);
            mtour(pop, tr, pb);
            mstep();
            cut = (int'(ms[7:0]) < xt) ? 1 + ((int'(ms[31:16]) * (ng - 1)) >> 16) : NGM;
            for (int g = 0; g < NGM; g++) mnxt[c][g] = (g < cut) ? mcur[pa][g] : mcur[pb][g];
            mstep();
            if (int'(ms[7:0]) < mt) mnxt[c][(int'(ms[15:8]) * ng) >> 8] = ms[31:16];
        end
        for (int p = 0; p < PM; p++) for (int g = 0; g < NGM; g++) mcur[p][g] = mnxt[p][g];
    endtask

    task automatic wr_gene(int p, int g, logic [15:0] d);
        @(negedge clk);
        chr_we = 1; chr_idx = 5'(p); chr_gene = 4'(g); chr_wdata = d;
        @(negedge clk);
        chr_we = 0;
        mcur[p][g] = d;
    endtask

    task automatic wr_fit(int p, logic [15:0] f);
        @(negedge clk);
        fit_we = 1; fit_idx = 5'(p); fit_val = f;
        @(negedge clk);
        fit_we = 0;
        mfit[p] = f;
    endtask

    task automatic cmp_pop(string tag);
        for (int p = 0; p < PM; p++) begin
            int bad = 0;
            logic [15:0] a = 0, e = 0;
            for (int g = 0; g < NGM; g++) begin
                chr_idx = 5'(p); chr_gene = 4'(g);
                #1;
                if (chr_rdata !== mcur[p][g] && bad == 0) begin
                    bad = 1; a = chr_rdata; e = mcur[p][g];
                end
            end
            chk($sformatf("%s slot %0d", tag, p), {16'h0, a}, {16'h0, e});
        end
    endtask

    task automatic wait_done(string tag);
        int n = 0;
        while (!done && n < 20000) begin @(negedge clk); n++; end
        chk({tag, " R8 done seen"}, {31'h0, done}, 32'h1);
        chk({tag, " R8 busy low at done"}, {31'h0, busy}, 32'h0);
        @(negedge clk);
        chk({tag, " R8 done one cycle"}, {31'h0, done}, 32'h0);
    endtask

    task automatic gen(string tag, logic [31:0] sd, int pop, int ng, int tr, bit two, int xt, int mt);
        @(negedge clk);
        seed = sd; pop_size = 5'(pop); gene_cnt = 4'(ng); tour_size = 4'(tr);
        elite_two = two; xover_thr = 8'(xt); mut_thr = 8'(mt); start = 1;
        @(negedge clk);
        start = 0;
        chk({tag, " R8 busy after start"}, {31'h0, busy}, 32'h1);
        model_gen(sd, pop, ng, tr, two, xt, mt);
        wait_done(tag);
        cmp_pop(tag);
    endtask

    task automatic load_rand(int fitmod);
        for (int p = 0; p < PM; p++) begin
            for (int g = 0; g < NGM; g++) wr_gene(p, g, 16'($urandom));
            wr_fit(p, 16'($urandom % fitmod));
        end
    endtask

    initial begin
        #4_000_000;
        nbad++;
        $display("FAIL watchdog R8 act=timeout exp=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int p = 0; p < PM; p++) begin
            mfit[p] = 0;
            for (int g = 0; g < NGM; g++) mcur[p][g] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'h0, busy}, 32'h0);
        chk("R1 done", {31'h0, done}, 32'h0);
        cmp_pop("R1 reset");

        // R2 write and read back
        load_rand(1000);
        cmp_pop("R2 readback");

        // default settings (R3 R5 R6 R7)
        gen("R3 default", 32'h1234_5678, 10, 8, 6, 0, 153, 128);
        // R4 zero seed replaced by constant
        gen("R4 zero seed", 32'h0, 10, 8, 6, 0, 153, 128);

        // R3 R5 ties: many equal fitness values, two elites, max sizes
        load_rand(3);
        gen("R5 ties", 32'hCAFE_0001, 20, 13, 8, 1, 153, 128);

        // R6 R7 no crossover and no mutation: children copy tournament winners
        load_rand(500);
        gen("R6 R7 thr zero", 32'h0BAD_F00D, 5, 2, 1, 0, 0, 0);
        // R6 R7 both near certain: crossover and mutation collide
        gen("R6 R7 thr max", 32'h7777_1111, 12, 13, 3, 1, 255, 255);

        // R2 R8 R9 activity during busy is ignored
        for (int p = 0; p < PM; p++) wr_fit(p, 16'(p == 0 ? 0 : 100 + p));
        @(negedge clk);
        seed = 32'h5555_AAAA; pop_size = 10; gene_cnt = 8; tour_size = 4;
        elite_two = 0; xover_thr = 150; mut_thr = 100; start = 1;
        @(negedge clk);
        start = 0;
        chk("R8 busy", {31'h0, busy}, 32'h1);
        model_gen(32'h5555_AAAA, 10, 8, 4, 0, 150, 100);
        chr_we = 1; chr_idx = 0; chr_gene = 0; chr_wdata = 16'hDEAD;
        fit_we = 1; fit_idx = 0; fit_val = 16'hFFFF;
        start = 1; seed = 32'h1; pop_size = 20; tour_size = 1; mut_thr = 0;
        @(negedge clk);
        chr_we = 0; fit_we = 0; start = 0;
        wait_done("R9 busy ignore");
        cmp_pop("R2 R9 busy ignore");

        // random configurations
        for (int k = 0; k < 6; k++) begin
            load_rand(200);
            gen("R5 random", $urandom, 5 + ($urandom % 16), 2 + ($urandom % 12),
                1 + ($urandom % 8), 1'($urandom), 77 + ($urandom % 154), 13 + ($urandom % 218));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
        $finish;
    end
endmodule